// File: doc/BRIEF.md
# Privileged Interrupt Priority Selector

This block decides, from the current interrupt state of a hart, whether an interrupt trap must be taken now and which cause code the trap carries. It sees the pending and enable vectors, the delegation mask, the current privilege level, the global machine and supervisor enable bits, and a debug-mode flag. It is combinational at heart, with an optional output register for timing closure.

Selection happens in two steps. First, machine-level candidates are formed from pending, enabled, non-delegated bits. Only if that set is empty are the delegated supervisor-level candidates considered. Second, a fixed class ordering narrows the survivors:
- platform bits at index 11 and above come first;
- then the external pair;
- then the software pair;
- then the timer pair.

The lowest index in the winning class is reported. The cause code has its top bit set to mark an interrupt and carries the chosen index in its low bits. A separate error flag reports a candidate set that fits no class.

Top module: `irq_prio_sel`

## Requirements
- R1: While `dbg_active` is 1, `take_irq`, `cause` and `no_class_err` are all 0, whatever the other inputs are.
- R2: If any bit is pending, enabled, not delegated and machine interrupts are globally on, only such bits are candidates. Delegated bits are ignored in that case.
- R3: Machine interrupts are globally on when `priv` (0 user, 1 supervisor, 3 machine) is below 3, or when it is 3 and `m_ie` is 1.
- R4: Delegated bits count only when they are pending and enabled and when supervisor interrupts are globally on. That is the case when `priv` is 0, or when `priv` is 1 and `s_ie` is 1. With `priv` 2 or 3, delegated bits never count.
- R5: If any candidate lies at bit index 11 or above, the lowest such index is chosen.
- R6: Otherwise, if supervisor-external (bit 9) is a candidate, it is chosen.
- R7: Otherwise, the lowest candidate among software bits 1 and 3 is chosen. Failing that, the lowest among timer bits 5 and 7 is chosen.
- R8: When an interrupt is taken, `cause` bit XLEN-1 is 1 and bits IW-1:0 hold the chosen index, with all other bits 0. When no interrupt is taken, `cause` is 0.
- R9: A nonempty candidate set that contains none of bits 1, 3, 5, 7, 9 or 11 and above sets `no_class_err` to 1 and `take_irq` to 0.
- R10: With `REG_OUT`=1, outputs follow their inputs one clock later and are 0 during reset. With `REG_OUT`=0, they follow within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend | input | NIRQ | Pending interrupt bits |
| enab | input | NIRQ | Per-bit interrupt enables |
| deleg | input | NIRQ | Delegation mask (1 = handled at supervisor level) |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_ie | input | 1 | Global machine interrupt enable |
| s_ie | input | 1 | Global supervisor interrupt enable |
| dbg_active | input | 1 | Hart is in debug mode |
| take_irq | output | 1 | An interrupt trap must be taken |
| cause | output | XLEN | Trap cause: interrupt flag in MSB, index in low bits |
| no_class_err | output | 1 | Candidates exist but none fit any priority class |

## Verification
The bench builds two instances with XLEN=32 and NIRQ=16. The first uses REG_OUT=1 and the second REG_OUT=0, so the one-cycle lag and the same-cycle path can be compared on identical stimulus. With sixteen interrupt lines, bits 12 to 15 are present as platform interrupts. The high class can therefore be pitted against machine-external and against lower classes. The narrow 32-bit cause keeps the MSB and index fields easy to predict for every privilege level and delegation pattern.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  // Standard bit positions of the architectural interrupt lines
  localparam int SSI_BIT = 1;
  localparam int MSI_BIT = 3;
  localparam int STI_BIT = 5;
  localparam int MTI_BIT = 7;
  localparam int SEI_BIT = 9;
  localparam int MEI_BIT = 11;

endpackage

// File: rtl/irq_prio_elig.sv
module irq_prio_elig
  import irq_prio_pkg::*;
#(
  parameter int NIRQ = 16
) (
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] enab,
  input  logic [NIRQ-1:0] deleg,
  input  logic [1:0]      priv,
  input  logic            m_ie,
  input  logic            s_ie,
  output logic [NIRQ-1:0] cand
);

  priv_e           cur;
  logic            m_on;
  logic            s_on;
  logic [NIRQ-1:0] live;
  logic [NIRQ-1:0] m_set;
  logic [NIRQ-1:0] s_set;

  assign cur   = priv_e'(priv);
  assign m_on  = (cur != PRIV_M) || m_ie;
  assign s_on  = (cur == PRIV_U) || ((cur == PRIV_S) && s_ie);
  assign live  = pend & enab;
  assign m_set = live & ~deleg & {NIRQ{m_on}};
  assign s_set = live &  deleg & {NIRQ{s_on}};

  // machine level wins outright whenever it has anything
  always_comb begin
    if (|m_set) cand = m_set;
    else        cand = s_set;
  end

endmodule

// File: rtl/irq_prio_class.sv
module irq_prio_class
  import irq_prio_pkg::*;
#(
  parameter int NIRQ = 16
) (
  input  logic [NIRQ-1:0] cand,
  output logic [NIRQ-1:0] restr,
  output logic            bad
);

  localparam logic [NIRQ-1:0] ONE    = NIRQ'(1);
  localparam logic [NIRQ-1:0] HIGH_M = ~((ONE << MEI_BIT) - ONE);
  localparam logic [NIRQ-1:0] EXT_M  = (ONE << SEI_BIT) | (ONE << MEI_BIT);
  localparam logic [NIRQ-1:0] SW_M   = (ONE << SSI_BIT) | (ONE << MSI_BIT);
  localparam logic [NIRQ-1:0] TMR_M  = (ONE << STI_BIT) | (ONE << MTI_BIT);

  always_comb begin
    if (|(cand & HIGH_M))      restr = cand & HIGH_M;
    else if (|(cand & EXT_M))  restr = cand & EXT_M;
    else if (|(cand & SW_M))   restr = cand & SW_M;
    else                       restr = cand & TMR_M;
  end

  assign bad = (|cand) && !(|restr);

endmodule

// File: rtl/irq_prio_lsb.sv
module irq_prio_lsb #(
  parameter int NIRQ = 16,
  parameter int IW   = $clog2(NIRQ)
) (
  input  logic [NIRQ-1:0] vec,
  output logic [IW-1:0]   idx,
  output logic            any
);

  assign any = |vec;

  always_comb begin
    idx = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int XLEN    = 64,
  parameter int NIRQ    = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIRQ-1:0]  pend,
  input  logic [NIRQ-1:0]  enab,
  input  logic [NIRQ-1:0]  deleg,
  input  logic [1:0]       priv,
  input  logic             m_ie,
  input  logic             s_ie,
  input  logic             dbg_active,
  output logic             take_irq,
  output logic [XLEN-1:0]  cause,
  output logic             no_class_err
);

  localparam int IW = $clog2(NIRQ);

  logic [NIRQ-1:0] cand;
  logic [NIRQ-1:0] restr;
  logic            bad;
  logic [IW-1:0]   idx_c;
  logic            any;
  logic            take_c;
  logic            err_c;
  logic [XLEN-1:0] cause_c;

  irq_prio_elig #(.NIRQ(NIRQ)) u_elig (
    .pend(pend), .enab(enab), .deleg(deleg), .priv(priv),
    .m_ie(m_ie), .s_ie(s_ie), .cand(cand)
  );

  irq_prio_class #(.NIRQ(NIRQ)) u_class (
    .cand(cand), .restr(restr), .bad(bad)
  );

  irq_prio_lsb #(.NIRQ(NIRQ), .IW(IW)) u_lsb (
    .vec(restr), .idx(idx_c), .any(any)
  );

  assign take_c  = any && !dbg_active;
  assign err_c   = bad && !dbg_active;
  assign cause_c = take_c ? {1'b1, {(XLEN-1-IW){1'b0}}, idx_c} : '0;

  generate
    if (REG_OUT) begin : g_reg
      logic            take_q;
      logic            err_q;
      logic [XLEN-1:0] cause_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          take_q  <= 1'b0;
          err_q   <= 1'b0;
          cause_q <= '0;
        end else begin
          take_q  <= take_c;
          err_q   <= err_c;
          cause_q <= cause_c;
        end
      end

      assign take_irq     = take_q;
      assign no_class_err = err_q;
      assign cause        = cause_q;
    end else begin : g_comb
      assign take_irq     = take_c;
      assign no_class_err = err_c;
      assign cause        = cause_c;
    end
  endgenerate

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int XLEN    = 64,
  parameter int NIRQ    = 16,
  parameter bit REG_OUT = 1'b1,
  parameter int IW      = $clog2(NIRQ)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NIRQ-1:0] pend,
  input logic [NIRQ-1:0] enab,
  input logic [NIRQ-1:0] deleg,
  input logic [1:0]      priv,
  input logic            m_ie,
  input logic            dbg_active,
  input logic            take_c,
  input logic [IW-1:0]   idx_c,
  input logic            err_c,
  input logic            take_irq,
  input logic [XLEN-1:0] cause,
  input logic            no_class_err
);

  logic m_live;
  assign m_live = (|(pend & enab & ~deleg)) && ((priv != 2'd3) || m_ie);

  // R1: debug mode blocks selection
  p_dbg_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active |-> (!take_c && !err_c));

  // R2: a live machine bit means the winner is not delegated
  p_mach_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_c && m_live) |-> !deleg[idx_c]);

  // R8: the chosen line really is pending and enabled
  p_pick_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_c |-> (pend[idx_c] && enab[idx_c]));

  // R8: cause format at the outputs
  p_cause_fmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq ? (cause[XLEN-1] && (cause[XLEN-2:0] >> IW) == '0) : (cause == '0));

  // R9: error and take never together
  p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_irq, no_class_err}));

  // R10: registered variant lags the selector by one edge
  p_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT != 1'b0) |=> (take_irq == $past(take_c) && no_class_err == $past(err_c)));

endmodule

bind irq_prio_sel irq_prio_chk #(.XLEN(XLEN), .NIRQ(NIRQ), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .enab(enab), .deleg(deleg),
  .priv(priv), .m_ie(m_ie), .dbg_active(dbg_active),
  .take_c(take_c), .idx_c(idx_c), .err_c(err_c),
  .take_irq(take_irq), .cause(cause), .no_class_err(no_class_err)
);

// File: tb/tb_irq_prio_sel.sv
`timescale 1ns/1ps
module tb_irq_prio_sel;

  localparam int XL = 32;
  localparam int NI = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] pend, enab, deleg;
  logic [1:0]    priv;
  logic          m_ie, s_ie, dbg;
  logic          tk_r, er_r, tk_c, er_c;
  logic [XL-1:0] cs_r, cs_c;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_prio_sel #(.XLEN(XL), .NIRQ(NI), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .pend(pend), .enab(enab), .deleg(deleg),
    .priv(priv), .m_ie(m_ie), .s_ie(s_ie), .dbg_active(dbg),
    .take_irq(tk_r), .cause(cs_r), .no_class_err(er_r));

  irq_prio_sel #(.XLEN(XL), .NIRQ(NI), .REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .pend(pend), .enab(enab), .deleg(deleg),
    .priv(priv), .m_ie(m_ie), .s_ie(s_ie), .dbg_active(dbg),
    .take_irq(tk_c), .cause(cs_c), .no_class_err(er_c));

  typedef struct packed {
    logic [15:0] p, e, d;
    logic [1:0]  pv;
    logic        mie, sie, db;
    logic        tk;
    logic [3:0]  ix;
    logic        er;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{16'h0080, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7,  1'b0}, // R3 M on
    '{16'h0080, 16'hFFFF, 16'h0000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0}, // R3 M off
    '{16'h0080, 16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7,  1'b0}, // R3 below M
    '{16'h0280, 16'hFFFF, 16'h0200, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7,  1'b0}, // R2
    '{16'h0200, 16'hFFFF, 16'h0200, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd9,  1'b0}, // R4 S on
    '{16'h0200, 16'hFFFF, 16'h0200, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0}, // R4 S off
    '{16'h0200, 16'hFFFF, 16'h0200, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9,  1'b0}, // R4 user
    '{16'h0200, 16'hFFFF, 16'h0200, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0}, // R4 in M
    '{16'h2880, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd11, 1'b0}, // R5
    '{16'h4008, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd14, 1'b0}, // R5
    '{16'h0288, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd9,  1'b0}, // R6
    '{16'h00A8, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3,  1'b0}, // R7 sw
    '{16'h00A0, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5,  1'b0}, // R7 timer
    '{16'h0005, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1}, // R9
    '{16'h0800, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  1'b0}, // R1
    '{16'h0005, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  1'b0}, // R1 err hidden
    '{16'h0800, 16'h0000, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0}  // R8 disabled
  };

  function automatic logic [XL-1:0] mk_cause(input logic tk, input logic [3:0] ix);
    return tk ? ({1'b1, 31'b0} | XL'(ix)) : '0;
  endfunction

  task automatic check(input string tag, input logic [XL-1:0] got, input logic [XL-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // independent reference model built from the requirement text
  task automatic ref_model(input logic [NI-1:0] p, e, d, input logic [1:0] pv,
                           input logic mie, sie, db,
                           output logic tk, output logic [3:0] ix, output logic er);
    logic mon, son, found;
    logic [NI-1:0] c, ms;
    mon = (pv != 2'd3) || mie;
    son = (pv == 2'd0) || ((pv == 2'd1) && sie);
    ms  = p & e & ~d & {NI{mon}};
    c   = (ms != 0) ? ms : (p & e & d & {NI{son}});
    tk = 1'b0; ix = 4'd0; er = 1'b0; found = 1'b0;
    if (!db) begin
      for (int i = 11; i < NI; i++)
        if (!found && c[i]) begin found = 1'b1; ix = 4'(i); end
      if (!found && c[9]) begin found = 1'b1; ix = 4'd9; end
      if (!found && c[1]) begin found = 1'b1; ix = 4'd1; end
      if (!found && c[3]) begin found = 1'b1; ix = 4'd3; end
      if (!found && c[5]) begin found = 1'b1; ix = 4'd5; end
      if (!found && c[7]) begin found = 1'b1; ix = 4'd7; end
      tk = found;
      er = !found && (c != 0);
    end
  endtask

  // drive at negedge, check same-cycle path, then registered path
  task automatic apply(input string tag, input logic [NI-1:0] p, e, d, input logic [1:0] pv,
                       input logic mie, sie, db, input logic tk, input logic [3:0] ix, input logic er);
    @(negedge clk);
    pend = p; enab = e; deleg = d; priv = pv; m_ie = mie; s_ie = sie; dbg = db;
    #1;
    check({tag, " comb take"},  XL'(tk_c), XL'(tk));
    check({tag, " comb cause"}, cs_c, mk_cause(tk, ix));
    check({tag, " comb err"},   XL'(er_c), XL'(er));
    @(negedge clk);
    check({tag, " reg take"},   XL'(tk_r), XL'(tk));
    check({tag, " reg cause"},  cs_r, mk_cause(tk, ix));
    check({tag, " reg err"},    XL'(er_r), XL'(er));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pend = 16'h0800; enab = 16'hFFFF; deleg = '0; priv = 2'd3; m_ie = 1'b1; s_ie = 1'b0; dbg = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset holds registered outputs at zero
    check("R10 reset take",  XL'(tk_r), '0);
    check("R10 reset cause", cs_r, '0);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      apply($sformatf("vector %0d", v), VT[v].p, VT[v].e, VT[v].d, VT[v].pv,
            VT[v].mie, VT[v].sie, VT[v].db, VT[v].tk, VT[v].ix, VT[v].er);

    // R10: one-cycle lag, registered output holds old value before edge
    apply("R10 setup", 16'h0800, 16'hFFFF, 16'h0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd11, 1'b0);
    @(negedge clk);
    dbg = 1'b1;
    #1;
    check("R10 lag reg old", XL'(tk_r), XL'(1));
    check("R1 comb now",     XL'(tk_c), XL'(0));
    @(negedge clk);
    check("R10 lag reg new", XL'(tk_r), XL'(0));

    // R10: asynchronous reset clears registered outputs mid-run
    apply("R10 pre", 16'h0008, 16'hFFFF, 16'h0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 async take",  XL'(tk_r), '0);
    check("R10 async cause", cs_r, '0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7 R8 R9: random sweep against the reference model
    for (int n = 0; n < 1500; n++) begin
      logic [NI-1:0] p, e, d;
      logic [1:0] pv;
      logic mie, sie, db, tk, er;
      logic [3:0] ix;
      p = NI'($urandom); e = NI'($urandom) | NI'($urandom);
      d = NI'($urandom); pv = 2'($urandom);
      mie = 1'($urandom); sie = 1'($urandom); db = ($urandom % 16) == 0;
      if ((n % 3) == 0) p = p & 16'h0FFF;
      if ((n % 5) == 0) p = p & 16'h01FF;
      ref_model(p, e, d, pv, mie, sie, db, tk, ix, er);
      apply("random R8", p, e, d, pv, mie, sie, db, tk, ix, er);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule